// File: doc/BRIEF.md
# Cache Tag Controller with Sweep Invalidation

This block keeps the valid bits and address tags of a small direct-mapped cache. It decides, for every core lookup, whether the access hits, must be handled as uncached, or may allocate a new line. It also answers bus snoops. It holds no data. A control write port loads three bits. An enable bit turns the cache on. A lock bit freezes the set of resident lines. A one-shot invalidate request sweeps every set back to invalid.

Control flow is a two-state machine. `ST_IDLE` serves lookups and snoops. The transition `IDLE->SWEEP` is taken when an invalidate request is pending and the cache is enabled. The self-transition `SWEEP->SWEEP` steps the set index by one per clock. The transition `SWEEP->IDLE` is taken after the last set is cleared. A pending request seen while disabled is consumed without leaving `ST_IDLE`. A core request made during the sweep is stalled, and the requester holds it until the sweep ends. Snoops made during the sweep are reported as misses.

Top module: `cache_tag_ctl`

## Requirements
- R1: After reset, `en_q`, `lock_q`, `inv_pend` and `busy` are 0 and every set is invalid.
- R2: When `ctl_wr` is 1 at a clock edge, `en_q` and `lock_q` take `ctl_en_in` and `ctl_lock_in` on the next cycle. If `ctl_inv_in` is also 1, `inv_pend` becomes 1. Writing 0 to `ctl_inv_in` never clears a pending request.
- R3: A pending request seen in `ST_IDLE` clears itself on the next cycle. If `en_q` is 1 on that edge, `busy` rises on the same next cycle.
- R4: A pending request seen while `en_q` is 0 is discarded. No sweep runs, and lines that were valid stay valid.
- R5: `busy` stays high for exactly NSETS cycles, one set cleared per cycle. After it falls, every earlier line misses.
- R6: While `busy` is 1, a core request gives `core_stall`=1 and `core_hit`=`core_alloc`=`core_uncached`=0. A snoop gives `snp_hit`=0 and changes no state.
- R7: When enabled and not locked, a lookup hits only if the set is valid and its tag matches. The address splits as offset bits [3:0], index bits [9:4] and tag bits [15:10]. A miss gives `core_uncached`=1 and `core_alloc`=1. The line is installed from the next cycle and replaces any other tag in that set.
- R8: With `en_q`=0, core requests give `core_uncached`=1 with no hit or alloc, snoops miss, and no valid bit changes.
- R9: With `lock_q`=1, hits are reported normally. Misses give `core_uncached`=1 and `core_alloc`=0. Snoops still hit and clear lines.
- R10: A snoop hit clears that set's valid bit from the next cycle. If a core allocation targets the same set in the same cycle, the allocated line is the one that remains valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_en_in | input | 1 | Enable value to write |
| ctl_lock_in | input | 1 | Lock value to write |
| ctl_inv_in | input | 1 | 1 requests an invalidate-all |
| en_q | output | 1 | Current enable bit |
| lock_q | output | 1 | Current lock bit |
| inv_pend | output | 1 | Invalidate request waiting to start |
| busy | output | 1 | Sweep in progress |
| core_req | input | 1 | Core lookup request |
| core_addr | input | AW | Core lookup address |
| core_stall | output | 1 | Request held off by the sweep |
| core_hit | output | 1 | Lookup hit |
| core_alloc | output | 1 | Miss may allocate; line installed next cycle |
| core_uncached | output | 1 | Access is to be handled as uncached |
| snp_req | input | 1 | Bus snoop request |
| snp_addr | input | AW | Snoop address |
| snp_hit | output | 1 | Snoop hit; the line is invalidated |

## Verification
The bench targets several ordering corners:
- An invalidate requested while disabled. A design that swept anyway would lose resident lines.
- A second invalidate written during a sweep, followed by a write of 0. A design that let the 0 clear the pending request would skip the second sweep.
- A snoop and an allocation to the same set in the same cycle. The wrong priority would leave the new line invalid.
- Locked misses. A design that allocated on them would turn later lookups into hits.
- Core requests held across the whole sweep. A design that served them early would hit on stale tags, and a design whose sweep ran off by one cycle would be caught by the busy-length check.

// File: rtl/ctag_pkg.sv
package ctag_pkg;
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_SWEEP = 1'b1
    } sweep_state_e;
endpackage

// File: rtl/ctag_ctrl_reg.sv
module ctag_ctrl_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic en_in,
    input  logic lock_in,
    input  logic inv_in,
    input  logic consume,
    output logic en_q,
    output logic lock_q,
    output logic inv_pend
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            lock_q   <= 1'b0;
            inv_pend <= 1'b0;
        end else begin
            if (wr) begin
                en_q   <= en_in;
                lock_q <= lock_in;
            end
            inv_pend <= (inv_pend & ~consume) | (wr & inv_in);
        end
    end
endmodule

// File: rtl/ctag_sweep_fsm.sv
module ctag_sweep_fsm
    import ctag_pkg::*;
#(
    parameter int NSETS = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     inv_pend,
    input  logic                     en_q,
    output logic                     consume,
    output logic                     busy,
    output logic                     clr_en,
    output logic [$clog2(NSETS)-1:0] clr_idx
);
    localparam int IDXW = $clog2(NSETS);
    localparam logic [IDXW-1:0] LAST = IDXW'(NSETS - 1);

    sweep_state_e    state_q, state_d;
    logic [IDXW-1:0] idx_q, idx_d;

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                if (inv_pend && en_q) begin
                    state_d = ST_SWEEP;
                    idx_d   = '0;
                end
            end
            ST_SWEEP: begin
                if (idx_q == LAST) begin
                    state_d = ST_IDLE;
                end else begin
                    idx_d = idx_q + 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    always_comb begin
        busy    = (state_q == ST_SWEEP);
        clr_en  = busy;
        clr_idx = idx_q;
        consume = (state_q == ST_IDLE) && inv_pend;
    end
endmodule

// File: rtl/ctag_tag_array.sv
module ctag_tag_array #(
    parameter int NSETS = 64,
    parameter int TAGW  = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(NSETS)-1:0] core_idx,
    input  logic [TAGW-1:0]          core_tag,
    output logic                     core_match,
    input  logic [$clog2(NSETS)-1:0] snp_idx,
    input  logic [TAGW-1:0]          snp_tag,
    output logic                     snp_match,
    input  logic                     clr_en,
    input  logic [$clog2(NSETS)-1:0] clr_idx,
    input  logic                     snp_clr,
    input  logic                     alloc,
    input  logic [$clog2(NSETS)-1:0] alloc_idx,
    input  logic [TAGW-1:0]          alloc_tag
);
    logic [NSETS-1:0] valid_q;
    logic [TAGW-1:0]  tag_q [NSETS];

    assign core_match = valid_q[core_idx] && (tag_q[core_idx] == core_tag);
    assign snp_match  = valid_q[snp_idx] && (tag_q[snp_idx] == snp_tag);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            if (clr_en)  valid_q[clr_idx]   <= 1'b0;
            if (snp_clr) valid_q[snp_idx]   <= 1'b0;
            if (alloc)   valid_q[alloc_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (alloc) tag_q[alloc_idx] <= alloc_tag;
    end
endmodule

// File: rtl/cache_tag_ctl.sv
module cache_tag_ctl #(
    parameter int AW         = 16,
    parameter int NSETS      = 64,
    parameter int LINE_BYTES = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_wr,
    input  logic          ctl_en_in,
    input  logic          ctl_lock_in,
    input  logic          ctl_inv_in,
    output logic          en_q,
    output logic          lock_q,
    output logic          inv_pend,
    output logic          busy,
    input  logic          core_req,
    input  logic [AW-1:0] core_addr,
    output logic          core_stall,
    output logic          core_hit,
    output logic          core_alloc,
    output logic          core_uncached,
    input  logic          snp_req,
    input  logic [AW-1:0] snp_addr,
    output logic          snp_hit
);
    localparam int OFFW = $clog2(LINE_BYTES);
    localparam int IDXW = $clog2(NSETS);
    localparam int TAGW = AW - OFFW - IDXW;

    logic            consume, clr_en, core_match, snp_match, active;
    logic [IDXW-1:0] clr_idx, core_idx, snp_idx;
    logic [TAGW-1:0] core_tag, snp_tag;

    assign core_idx = core_addr[OFFW +: IDXW];
    assign core_tag = core_addr[AW-1 -: TAGW];
    assign snp_idx  = snp_addr[OFFW +: IDXW];
    assign snp_tag  = snp_addr[AW-1 -: TAGW];

    ctag_ctrl_reg ctrl_i (
        .clk(clk), .rst_n(rst_n), .wr(ctl_wr), .en_in(ctl_en_in),
        .lock_in(ctl_lock_in), .inv_in(ctl_inv_in), .consume(consume),
        .en_q(en_q), .lock_q(lock_q), .inv_pend(inv_pend)
    );

    ctag_sweep_fsm #(.NSETS(NSETS)) fsm_i (
        .clk(clk), .rst_n(rst_n), .inv_pend(inv_pend), .en_q(en_q),
        .consume(consume), .busy(busy), .clr_en(clr_en), .clr_idx(clr_idx)
    );

    ctag_tag_array #(.NSETS(NSETS), .TAGW(TAGW)) tags_i (
        .clk(clk), .rst_n(rst_n),
        .core_idx(core_idx), .core_tag(core_tag), .core_match(core_match),
        .snp_idx(snp_idx), .snp_tag(snp_tag), .snp_match(snp_match),
        .clr_en(clr_en), .clr_idx(clr_idx), .snp_clr(snp_hit),
        .alloc(core_alloc), .alloc_idx(core_idx), .alloc_tag(core_tag)
    );

    always_comb begin
        active        = core_req && !busy;
        core_stall    = core_req && busy;
        core_hit      = active && en_q && core_match;
        core_alloc    = active && en_q && !lock_q && !core_match;
        core_uncached = active && !core_hit;
        snp_hit       = snp_req && !busy && en_q && snp_match;
    end
endmodule

// File: rtl/cache_tag_ctl_chk.sv
module cache_tag_ctl_chk #(
    parameter int AW    = 16,
    parameter int NSETS = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ctl_wr,
    input logic          ctl_en_in,
    input logic          ctl_lock_in,
    input logic          ctl_inv_in,
    input logic          en_q,
    input logic          lock_q,
    input logic          inv_pend,
    input logic          busy,
    input logic          core_req,
    input logic [AW-1:0] core_addr,
    input logic          core_stall,
    input logic          core_hit,
    input logic          core_alloc,
    input logic          core_uncached,
    input logic          snp_req,
    input logic [AW-1:0] snp_addr,
    input logic          snp_hit
);
    int busy_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)    busy_cnt <= 0;
        else if (busy) busy_cnt <= busy_cnt + 1;
        else           busy_cnt <= 0;
    end

    assert_wr_pend_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_inv_in) |=> inv_pend);

    assert_self_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_pend && !busy && !(ctl_wr && ctl_inv_in)) |=> !inv_pend);

    assert_sweep_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_pend && !busy && en_q) |=> busy);

    assert_discard_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_pend && !busy && !en_q) |=> !busy);

    assert_sweep_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_cnt == NSETS));

    assert_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!core_hit && !core_alloc && !core_uncached && !snp_hit
                  && (core_stall == core_req)));

    assert_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> (!core_hit && !core_alloc && !snp_hit));

    assert_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q && core_req && !busy && !core_hit) |-> (core_uncached && !core_alloc));

    assert_snoop_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_hit && !core_req) ##1 (snp_req && $stable(snp_addr)) |-> !snp_hit);
endmodule

bind cache_tag_ctl cache_tag_ctl_chk #(.AW(AW), .NSETS(NSETS)) chk_i (.*);

// File: tb/cache_tag_ctl_tb_top.sv
module cache_tag_ctl_tb_top;
    localparam int AW = 16;
    localparam int NS = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_wr = 0, ctl_en_in = 0, ctl_lock_in = 0, ctl_inv_in = 0;
    logic core_req = 0, snp_req = 0;
    logic [AW-1:0] core_addr = '0, snp_addr = '0;
    logic en_q, lock_q, inv_pend, busy;
    logic core_stall, core_hit, core_alloc, core_uncached, snp_hit;

    always #4 clk = ~clk;

    cache_tag_ctl #(.AW(AW), .NSETS(NS), .LINE_BYTES(16)) dut_i (.*);

    int total = 0, fails = 0;
    bit mv [NS];
    int mt [NS];
    bit m_en, m_lock, m_pend, m_busy;
    int m_sidx;
    int e_hit, e_snp, e_alloc;

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int aidx(input logic [AW-1:0] a);
        return (int'(a) / 16) % NS;
    endfunction
    function automatic int atag(input logic [AW-1:0] a);
        return int'(a) / 1024;
    endfunction

    task automatic compare();
        int ci = aidx(core_addr), si = aidx(snp_addr);
        e_hit   = (core_req && !m_busy && m_en && mv[ci] && mt[ci] == atag(core_addr)) ? 1 : 0;
        e_alloc = (core_req && !m_busy && m_en && !m_lock && e_hit == 0) ? 1 : 0;
        e_snp   = (snp_req && !m_busy && m_en && mv[si] && mt[si] == atag(snp_addr)) ? 1 : 0;
        chk("R2 en_q", int'(en_q), int'(m_en));
        chk("R2 lock_q", int'(lock_q), int'(m_lock));
        chk("R3 inv_pend", int'(inv_pend), int'(m_pend));
        chk("R5 busy", int'(busy), int'(m_busy));
        chk("R6 core_stall", int'(core_stall), (core_req && m_busy) ? 1 : 0);
        chk("R7 core_hit", int'(core_hit), e_hit);
        chk("R7 core_alloc", int'(core_alloc), e_alloc);
        chk("R7 core_uncached", int'(core_uncached), (core_req && !m_busy && e_hit == 0) ? 1 : 0);
        chk("R10 snp_hit", int'(snp_hit), e_snp);
    endtask

    task automatic advance();
        bit start = !m_busy && m_pend && m_en;
        bit np = (!m_busy && m_pend) ? (ctl_wr && ctl_inv_in) : (m_pend || (ctl_wr && ctl_inv_in));
        if (e_snp == 1) mv[aidx(snp_addr)] = 0;
        if (e_alloc == 1) begin
            mv[aidx(core_addr)] = 1;
            mt[aidx(core_addr)] = atag(core_addr);
        end
        if (m_busy) begin
            mv[m_sidx] = 0;
            if (m_sidx == NS - 1) m_busy = 0;
            else m_sidx++;
        end else if (start) begin
            m_busy = 1;
            m_sidx = 0;
        end
        if (ctl_wr) begin
            m_en = ctl_en_in;
            m_lock = ctl_lock_in;
        end
        m_pend = np;
    endtask

    task automatic tick();
        #1 compare();
        @(posedge clk);
        advance();
        @(negedge clk);
    endtask

    task automatic idle_in();
        ctl_wr = 0; ctl_inv_in = 0; core_req = 0; snp_req = 0;
    endtask

    task automatic wr_ctl(input bit en, input bit lk, input bit inv);
        ctl_wr = 1; ctl_en_in = en; ctl_lock_in = lk; ctl_inv_in = inv;
        tick();
        ctl_wr = 0; ctl_inv_in = 0;
    endtask

    task automatic look(input int a);
        core_req = 1; core_addr = AW'(a);
        tick();
        core_req = 0;
    endtask

    task automatic look_expect(input int a, input string tag, input int exp_hit);
        core_req = 1; core_addr = AW'(a);
        #1 chk(tag, int'(core_hit), exp_hit);
        #0 tick();
        core_req = 0;
    endtask

    initial begin
        #(200000 * 8);
        fails++; total++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        int seed = 7;
        int bc;
        for (int i = 0; i < NS; i++) begin mv[i] = 0; mt[i] = 0; end
        m_en = 0; m_lock = 0; m_pend = 0; m_busy = 0; m_sidx = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        #1 chk("R1 en_q", int'(en_q), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 inv_pend", int'(inv_pend), 0);
        @(negedge clk);

        // R8: disabled cache, nothing allocated
        look(16'h0450); look(16'h0450);
        snp_req = 1; snp_addr = 16'h0450; tick(); snp_req = 0;
        wr_ctl(1, 0, 0);
        look_expect(16'h0450, "R8 no alloc while disabled", 0);

        // R7: allocate, hit, conflict replace
        look_expect(16'h0450, "R7 hit after alloc", 1);
        look(16'h0850);
        look_expect(16'h0450, "R7 conflict replaced", 0);
        look(16'h1230); look(16'h2460);

        // random traffic
        for (int i = 0; i < 200; i++) begin
            seed = seed * 1103515245 + 12345;
            core_req = seed[16];
            core_addr = AW'((seed[20:19]) * 1024 + (seed[24:22]) * 16 + seed[28:25]);
            snp_req = seed[17] & seed[18];
            snp_addr = AW'((seed[30:29]) * 1024 + (seed[23:21]) * 16);
            tick();
        end
        idle_in();

        // R10: snoop and same-set allocation in the same cycle
        look(16'h0450);
        snp_req = 1; snp_addr = 16'h0450; core_req = 1; core_addr = 16'h0850;
        tick(); idle_in();
        look_expect(16'h0850, "R10 alloc wins over snoop clear", 1);
        snp_req = 1; snp_addr = 16'h0850; tick(); idle_in();
        look_expect(16'h0850, "R10 snoop cleared line", 0);

        // R9: lock
        look(16'h0c70);
        wr_ctl(1, 1, 0);
        look_expect(16'h0c70, "R9 locked hit", 1);
        look(16'h1c80);
        look_expect(16'h1c80, "R9 locked miss not allocated", 0);
        snp_req = 1; snp_addr = 16'h0c70; tick(); idle_in();
        look_expect(16'h0c70, "R9 snoop clears under lock", 0);
        wr_ctl(1, 0, 0);
        look(16'h0c70); look(16'h1230);

        // R4: invalidate while disabled is discarded
        wr_ctl(0, 0, 1);
        tick(); tick();
        wr_ctl(1, 0, 0);
        look_expect(16'h0c70, "R4 line kept after discard", 1);

        // R5/R6: sweep with held request and snoops
        wr_ctl(1, 0, 1);
        core_req = 1; core_addr = 16'h0c70; snp_req = 1; snp_addr = 16'h1230;
        tick();
        bc = 0;
        while (busy && bc < 1000) begin
            bc++;
            if (bc == 10) begin ctl_wr = 1; ctl_en_in = 1; ctl_inv_in = 1; end
            else if (bc == 20) begin ctl_wr = 1; ctl_en_in = 1; ctl_inv_in = 0; end
            else ctl_wr = 0;
            tick();
        end
        ctl_wr = 0; ctl_inv_in = 0;
        chk("R5 sweep length", bc, NS);
        chk("R2 pending kept after zero write", int'(inv_pend), 1);
        tick();
        bc = 0;
        while (busy && bc < 1000) begin bc++; tick(); end
        chk("R5 second sweep length", bc, NS);
        idle_in();
        look_expect(16'h0c70, "R5 miss after sweep", 0);
        look_expect(16'h1230, "R5 miss after sweep", 0);
        repeat (4) tick();

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule